// File: doc/BRIEF.md
# Two-Stage SCL Rate Divider

This block turns the system clock into the bit timing of an I2C controller. Two cascaded counters divide the clock. The first stage, a prescaler, fires once every A+1 clocks. The second stage counts B+1 of those pulses and then emits one base tick. Twenty-two base ticks make one SCL period. The SCL rate is therefore the input clock divided by 22 × (A+1) × (B+1). Software chooses the divisor pair so that the bus stays at or below 400 kHz, and writes the pair into a 16-bit control word.

A phase counter steps through the 22 base ticks of each period. From the phase it drives the SCL level: low for the first twelve phases and released high for the last ten. It also emits single-cycle strobes for the byte engine: one where SDA may change, one where SDA is sampled, one where SCL rises and one where a new period begins. A target may hold SCL low during the high half. When the synchronized line reads low there, the phase counter waits, which honours clock stretching. While `run` is low, all counters sit at zero and SCL is released, so every transfer starts on a clean period boundary.

Top module: `scl_rate_gen`

## Requirements
- R1: The prescale divisor A is `ctrl_word[15:14]` and the second-stage divisor B is `ctrl_word[13:8]`; the other bits have no effect. With T = (A+1)×(B+1), consecutive `strobe_fall` pulses are 22×T clocks apart.
- R2: Each phase lasts T clocks. While running, `scl_out` is 0 for phases 0 to 11 and 1 for phases 12 to 21, so SCL stays high for 10×T clocks from `strobe_rise` to the next `strobe_fall`.
- R3: `strobe_setup` is a one-cycle pulse in the cycle in which `phase` first shows 5, while `scl_out` is low.
- R4: `strobe_sample` is a one-cycle pulse in the cycle in which `phase` first shows 17, while `scl_out` is high.
- R5: `strobe_rise` pulses when `phase` enters 12, and `strobe_fall` pulses when `phase` wraps from 21 to 0. At most one of the four strobes is high in any cycle.
- R6: One edge after `run` is sampled low, `phase` is 0, `scl_out` is 1 and no strobe is high. When `run` is first sampled high at edge E0, phase 0 lasts a full T, so the first `strobe_rise` appears 12×T edges after E0.
- R7: `scl_in` passes through a two-flop synchronizer. If the synchronized line is low while `phase` is 12 or above, `phase` holds until the line reads high. Advance resumes at the third edge after the release at the earliest, and no later than the (2+T)-th edge. In phases 0 to 11, `scl_in` is ignored.
- R8: During and right after reset, `phase` is 0, `scl_out` is 1 and all strobes are 0. `phase` never exceeds 21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | High while a transfer is in progress; low clears all counters |
| ctrl_word | input | 16 | Control word; bits 15:14 hold A, bits 13:8 hold B |
| scl_in | input | 1 | Sensed SCL line level, asynchronous |
| scl_out | output | 1 | Driven SCL level (1 = released) |
| phase | output | 5 | Current phase within the 22-tick period |
| strobe_fall | output | 1 | Pulse when a new period begins (SCL falls) |
| strobe_rise | output | 1 | Pulse when SCL is released high |
| strobe_setup | output | 1 | Pulse at the SDA change point (phase 5) |
| strobe_sample | output | 1 | Pulse at the SDA sample point (phase 17) |

## Verification
A miscounting prescaler or second stage shows up as wrong spacing between strobes. The error appears within the first period: the first rise arrives at the wrong edge, and the gap between falls departs from 22×T. The bench measures these spacings at edge accuracy for several divisor pairs, including the largest. A stuck phase counter or a faulty stall shows at the ports within one period. Either `scl_out` no longer matches the phase, or the phase fails to hold while SCL is stretched, or fails to move again within 2+T edges of the release. A missing idle clear appears one edge after `run` falls.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

   // Timing strobes handed to the byte engine
   typedef struct packed {
      logic fall;
      logic rise;
      logic setup;
      logic sample;
   } scl_strobe_t;

   localparam scl_strobe_t STROBE_NONE = '0;

endpackage

// File: rtl/scl_div_stage.sv
// One counting stage: pulses 'wrap' on every (limit+1)-th step.
module scl_div_stage #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         step,
   input  logic [W-1:0] limit,
   output logic         wrap
);

   logic [W-1:0] cnt;

   // >= so that a divisor lowered mid-count still wraps promptly
   assign wrap = step && (cnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (step)
         cnt <= wrap ? '0 : cnt + W'(1);
   end

endmodule

// File: rtl/scl_line_sync.sv
// Synchronizer for the sensed SCL level; STAGES = 0 passes it straight through.
module scl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_direct
         assign q = d;
      end else begin : g_flops
         logic [STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '1;
            end else begin
               sh[0] <= d;
               for (int i = 1; i < STAGES; i++)
                  sh[i] <= sh[i-1];
            end
         end
         assign q = sh[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/scl_phase_seq.sv
// Steps through the SCL period one base tick at a time and raises strobes.
module scl_phase_seq
   import scl_div_pkg::*;
#(
   parameter int PHASES     = 22,
   parameter int HIGH_START = 12,
   parameter int SETUP_AT   = 5,
   parameter int SAMPLE_AT  = 17,
   parameter int PW         = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          base_tick,
   input  logic          line_hi,
   output logic [PW-1:0] phase,
   output logic          level_hi,
   output scl_strobe_t   strb
);

   localparam logic [PW-1:0] LAST_PH   = PW'(PHASES - 1);
   localparam logic [PW-1:0] HIGH_PH   = PW'(HIGH_START);
   localparam logic [PW-1:0] SETUP_PH  = PW'(SETUP_AT);
   localparam logic [PW-1:0] SAMPLE_PH = PW'(SAMPLE_AT);

   logic          stall;
   logic          adv;
   logic [PW-1:0] nxt;

   assign level_hi = (phase >= HIGH_PH);
   assign stall    = level_hi && !line_hi;   // a target is stretching SCL
   assign adv      = base_tick && !stall;
   assign nxt      = (phase == LAST_PH) ? '0 : phase + PW'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         strb  <= STROBE_NONE;
      end else if (clr) begin
         phase <= '0;
         strb  <= STROBE_NONE;
      end else begin
         strb <= STROBE_NONE;
         if (adv) begin
            phase       <= nxt;
            strb.fall   <= (nxt == '0);
            strb.rise   <= (nxt == HIGH_PH);
            strb.setup  <= (nxt == SETUP_PH);
            strb.sample <= (nxt == SAMPLE_PH);
         end
      end
   end

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
   import scl_div_pkg::*;
#(
   parameter int CTRL_W      = 16,
   parameter int A_W         = 2,
   parameter int A_LSB       = 14,
   parameter int B_W         = 6,
   parameter int B_LSB       = 8,
   parameter int PHASES      = 22,
   parameter int HIGH_START  = 12,
   parameter int SETUP_AT    = 5,
   parameter int SAMPLE_AT   = 17,
   parameter int SYNC_STAGES = 2,
   parameter int PHASE_W     = $clog2(PHASES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [CTRL_W-1:0]  ctrl_word,
   input  logic               scl_in,
   output logic               scl_out,
   output logic [PHASE_W-1:0] phase,
   output logic               strobe_fall,
   output logic               strobe_rise,
   output logic               strobe_setup,
   output logic               strobe_sample
);

   // Elaboration-time parameter checks
   generate
      if (A_LSB + A_W > CTRL_W || B_LSB + B_W > CTRL_W) begin : g_bad_field
         $error("divisor field lies outside the control word");
      end
      if (PHASES > (1 << PHASE_W)) begin : g_bad_pw
         $error("PHASE_W too narrow for PHASES");
      end
      if (!(SETUP_AT > 0 && SETUP_AT < HIGH_START && HIGH_START < SAMPLE_AT
            && SAMPLE_AT < PHASES)) begin : g_bad_order
         $error("phase points must satisfy 0 < setup < high start < sample < phases");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   logic [A_W-1:0] div_a;
   logic [B_W-1:0] div_b;
   logic           ctrl_unused;
   logic           active;
   logic           pre_en;
   logic           base_tick;
   logic           line_q;
   logic           level_hi;
   scl_strobe_t    strb;

   assign div_a       = ctrl_word[A_LSB +: A_W];
   assign div_b       = ctrl_word[B_LSB +: B_W];
   assign ctrl_unused = ^ctrl_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active <= 1'b0;
      else
         active <= run;
   end

   scl_div_stage #(.W(A_W)) u_prescale (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!run),
      .step  (active),
      .limit (div_a),
      .wrap  (pre_en)
   );

   scl_div_stage #(.W(B_W)) u_base (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (!run),
      .step  (pre_en),
      .limit (div_b),
      .wrap  (base_tick)
   );

   scl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (line_q)
   );

   scl_phase_seq #(
      .PHASES     (PHASES),
      .HIGH_START (HIGH_START),
      .SETUP_AT   (SETUP_AT),
      .SAMPLE_AT  (SAMPLE_AT),
      .PW         (PHASE_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (!run),
      .base_tick (base_tick),
      .line_hi   (line_q),
      .phase     (phase),
      .level_hi  (level_hi),
      .strb      (strb)
   );

   assign scl_out       = !active || level_hi;
   assign strobe_fall   = strb.fall;
   assign strobe_rise   = strb.rise;
   assign strobe_setup  = strb.setup;
   assign strobe_sample = strb.sample;

endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk #(
   parameter int PHASES     = 22,
   parameter int HIGH_START = 12,
   parameter int SETUP_AT   = 5,
   parameter int SAMPLE_AT  = 17,
   parameter int PHASE_W    = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               run,
   input logic               scl_out,
   input logic [PHASE_W-1:0] phase,
   input logic               strobe_fall,
   input logic               strobe_rise,
   input logic               strobe_setup,
   input logic               strobe_sample,
   input logic               line_q
);

   AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_fall |-> (phase == '0 && $past(phase) == PHASE_W'(PHASES - 1))); // R1

   AST_LEVEL_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) |-> (scl_out == (phase >= PHASE_W'(HIGH_START)))); // R2

   AST_SETUP_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_setup |-> (phase == PHASE_W'(SETUP_AT) && !scl_out)); // R3

   AST_SAMPLE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_sample |-> (phase == PHASE_W'(SAMPLE_AT) && scl_out)); // R4

   AST_RISE_POINT: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_rise |-> (phase == PHASE_W'(HIGH_START) && scl_out)); // R5

   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({strobe_fall, strobe_rise, strobe_setup, strobe_sample})); // R5

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (scl_out && phase == '0 && !strobe_fall && !strobe_rise)); // R6

   AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (run && phase >= PHASE_W'(HIGH_START) && !line_q) |=> $stable(phase)); // R7

   AST_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      int'(phase) < PHASES); // R8

endmodule

bind scl_rate_gen scl_rate_gen_chk #(
   .PHASES     (PHASES),
   .HIGH_START (HIGH_START),
   .SETUP_AT   (SETUP_AT),
   .SAMPLE_AT  (SAMPLE_AT),
   .PHASE_W    (PHASE_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .run           (run),
   .scl_out       (scl_out),
   .phase         (phase),
   .strobe_fall   (strobe_fall),
   .strobe_rise   (strobe_rise),
   .strobe_setup  (strobe_setup),
   .strobe_sample (strobe_sample),
   .line_q        (line_q)
);

// File: tb/scl_rate_gen_test.sv
`timescale 1ns/1ps
module scl_rate_gen_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [15:0] ctrl_word = 16'h0000;
   logic        scl_in = 1'b1;
   logic        scl_out;
   logic [4:0]  phase;
   logic        strobe_fall, strobe_rise, strobe_setup, strobe_sample;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   scl_rate_gen uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .run           (run),
      .ctrl_word     (ctrl_word),
      .scl_in        (scl_in),
      .scl_out       (scl_out),
      .phase         (phase),
      .strobe_fall   (strobe_fall),
      .strobe_rise   (strobe_rise),
      .strobe_setup  (strobe_setup),
      .strobe_sample (strobe_sample)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int strobe_cnt();
      return int'(strobe_fall) + int'(strobe_rise) + int'(strobe_setup) + int'(strobe_sample);
   endfunction

   // R8: reset state
   task automatic test_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(phase == 0 && scl_out == 1'b1 && strobe_cnt() == 0, "R8",
          "reset phase/scl/strobes", int'(phase), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(phase == 0 && scl_out == 1'b1 && strobe_cnt() == 0, "R8",
          "after reset release", {int'(scl_out), int'(phase)}, 32);
   endtask

   // R1..R6: full timing of two periods for one divisor pair
   task automatic run_case(input int a, input int b, input logic [7:0] junk);
      int t = (a + 1) * (b + 1);
      int n = 0;
      int rise1 = 0, fall1 = 0, fall2 = 0, setup1 = 0, sample1 = 0;
      int bad_lvl = 0, multi = 0;
      @(negedge clk);
      ctrl_word = {a[1:0], b[5:0], junk};
      run = 1'b1;
      while (fall2 == 0 && n < 50 * t + 10) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (strobe_rise && rise1 == 0) rise1 = n;
         if (strobe_setup && setup1 == 0) setup1 = n;
         if (strobe_sample && sample1 == 0) sample1 = n;
         if (strobe_fall) begin
            if (fall1 == 0) fall1 = n;
            else if (fall2 == 0) fall2 = n;
         end
         if (scl_out != (phase >= 5'd12)) bad_lvl++;
         if (strobe_cnt() > 1) multi++;
      end
      chk(rise1 == 12 * t + 1, "R6", "first rise edge index", rise1, 12 * t + 1);
      chk(setup1 == 5 * t + 1, "R3", "setup strobe edge index", setup1, 5 * t + 1);
      chk(sample1 == 17 * t + 1, "R4", "sample strobe edge index", sample1, 17 * t + 1);
      chk(fall1 - rise1 == 10 * t, "R2", "high time", fall1 - rise1, 10 * t);
      chk(fall2 - fall1 == 22 * t, "R1", "SCL period", fall2 - fall1, 22 * t);
      chk(bad_lvl == 0, "R2", "scl level vs phase mismatches", bad_lvl, 0);
      chk(multi == 0, "R5", "cycles with several strobes", multi, 0);
      run = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(phase == 0 && scl_out == 1'b1 && strobe_cnt() == 0, "R6",
          "idle after run low", int'(phase), 0);
   endtask

   // R2/R6: abort mid-period returns to idle at once
   task automatic test_abort();
      @(negedge clk);
      ctrl_word = 16'h0000;
      run = 1'b1;
      repeat (7) @(negedge clk);
      chk(phase == 6, "R2", "phase after 7 edges at T=1", int'(phase), 6);
      run = 1'b0;
      @(negedge clk);
      chk(phase == 0 && scl_out == 1'b1, "R6", "abort clears phase", int'(phase), 0);
   endtask

   // R7: stretching in the high half stalls, low half ignores the line
   task automatic test_stretch();
      int k = 0;
      int held_bad = 0;
      @(negedge clk);
      ctrl_word = {2'd0, 6'd1, 8'h00};   // T = 2
      scl_in = 1'b1;
      run = 1'b1;
      while (phase != 5'd3 && k < 100) begin @(negedge clk); k++; end
      scl_in = 1'b0;
      k = 0;
      while (phase != 5'd12 && k < 100) begin @(negedge clk); k++; end
      chk(phase == 12 && k <= 9 * 2 + 2, "R7", "low half ignores scl_in (edges)", k, 18);
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (phase != 5'd12 || scl_out != 1'b1 || strobe_fall) held_bad++;
      end
      chk(held_bad == 0, "R7", "phase held during stretch", held_bad, 0);
      scl_in = 1'b1;
      k = 0;
      while (phase == 5'd12 && k < 50) begin @(posedge clk); k++; @(negedge clk); end
      chk(k >= 3 && k <= 4 && phase == 13, "R7", "resume edge after release", k, 4);
      run = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      test_reset();
      run_case(0, 0, 8'hA5);
      run_case(1, 2, 8'hFF);
      run_case(3, 0, 8'h3C);
      run_case(2, 5, 8'h00);
      run_case(3, 63, 8'h5A);
      test_abort();
      test_stretch();
      run_case(0, 1, 8'h81);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      done = 1'b1;
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule